// File: doc/BRIEF.md
# Wrapping Burst Read Address Sequencer

This block drives the word-address stream and the data-valid and ready timing for a synchronous burst read out of a memory array. The host presents a start address and pulses an address strobe while the enable is high. The sequencer captures that address and its configuration, then waits a programmable number of initial latency cycles. After that it emits one word address per clock, with a valid flag beside it.

The walk is either continuous linear, which pauses for a fixed number of extra cycles each time it crosses a 64-word boundary, or a wraparound inside an aligned group of 8, 16 or 32 words. A ready output either follows the valid flag exactly or leads it by one clock, as set by a configuration bit. Dropping the enable ends the burst at the next edge. The memory access itself is outside this block. It only supplies the address and the strobes.

Top module: `bseq_top`

## Requirements
- R1: While `rst` is high at a clock edge, the edge leaves `word_valid`, `rdy` and `word_addr` at zero, and the sequencer is idle.
- R2: An edge that samples `en` and `strobe` both high captures `start_addr`, `cfg_wait`, `cfg_mode` and `cfg_rdy_early`, and drives `word_valid` and `rdy` low. This also applies during a running burst, which it abandons and restarts.
- R3: Take the capturing edge as edge 0 and let L be `cfg_wait`, or 2 when `cfg_wait` is below 2. The first word is valid in the cycle after edge L.
- R4: In linear mode (`cfg_mode` = 00), each word address is the previous one plus 1, modulo 2^AW.
- R5: `cfg_mode` 01, 10 and 11 select wraparound in aligned groups of 8, 16 and 32 words. The burst starts at the captured address, steps by 1, and goes from the group's last word back to its first, with the upper address bits unchanged.
- R6: In linear mode, after the word whose low 6 address bits are all ones, `word_valid` stays low for BOUND_GAP cycles. The next word follows after that.
- R7: With the captured `cfg_rdy_early` = 0, `rdy` equals `word_valid` in every cycle.
- R8: With the captured `cfg_rdy_early` = 1, `rdy` in each cycle equals `word_valid` in the following cycle, provided the edge between them samples `en` high and `strobe` low.
- R9: An edge that samples `en` low clears `word_valid` and `rdy` and makes the sequencer idle. A `strobe` sampled with `en` low is ignored, and no word appears until a later capture.
- R10: Changing any `cfg_*` input or `start_addr` while no capture occurs has no effect on the burst in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Chip enable; low ends any burst |
| strobe | input | 1 | Address strobe; starts a burst when sampled with en |
| start_addr | input | AW | Word address of the first beat |
| cfg_wait | input | WAIT_W | Initial latency in clocks (values below 2 act as 2) |
| cfg_mode | input | 2 | 00 linear, 01 wrap 8, 10 wrap 16, 11 wrap 32 |
| cfg_rdy_early | input | 1 | 0: rdy with data, 1: rdy one clock ahead |
| word_addr | output | AW | Word address of the current beat |
| word_valid | output | 1 | Current beat carries a valid address |
| rdy | output | 1 | Ready indication to the bus |

## Verification
The bench builds the sequencer with AW = 10, WAIT_W = 4 and BOUND_GAP = 3, leaving BOUND_LOG2 at 6. A 10-bit address space lets a linear burst run off the top of the space and wrap to zero in a few cycles. The same beat also crosses a 64-word boundary, so the pause and the address overflow are exercised together. A three-cycle pause is long enough to show that early ready falls with the last word before the pause and rises exactly one clock before the word after it. A 4-bit latency field reaches both the clamped values 0 and 1 and latencies long enough to change the configuration while the burst is still waiting.

// File: rtl/bseq_pkg.sv
package bseq_pkg;

  typedef enum logic [1:0] {
    M_LINEAR = 2'b00,
    M_WRAP8  = 2'b01,
    M_WRAP16 = 2'b10,
    M_WRAP32 = 2'b11
  } bseq_mode_e;

  typedef enum logic [1:0] {
    S_IDLE  = 2'b00,
    S_WAIT  = 2'b01,
    S_BURST = 2'b10,
    S_GAP   = 2'b11
  } bseq_st_e;

  localparam int unsigned MIN_LATENCY = 2;

endpackage

// File: rtl/bseq_addr_step.sv
module bseq_addr_step
  import bseq_pkg::*;
#(
  parameter int unsigned AW = 22
) (
  input  logic [AW-1:0] cur_addr,
  input  bseq_mode_e    mode,
  output logic [AW-1:0] nxt_addr,
  output logic [AW-1:0] wrap_mask
);
  // Bits inside the mask step and roll over; bits outside it are held.
  localparam int unsigned NMODES = 4;
  logic [AW-1:0] mask_tab [NMODES];

  for (genvar m = 0; m < NMODES; m++) begin : g_mask
    if (m == 0) begin : g_lin
      assign mask_tab[m] = '1;
    end else begin : g_wrap
      assign mask_tab[m] = AW'((1 << (m + 2)) - 1);
    end
  end

  assign wrap_mask = mask_tab[mode];

  always_comb begin
    nxt_addr = (cur_addr & ~wrap_mask) | ((cur_addr + AW'(1)) & wrap_mask);
  end

endmodule

// File: rtl/bseq_lat_ctrl.sv
module bseq_lat_ctrl
  import bseq_pkg::*;
#(
  parameter int unsigned AW         = 22,
  parameter int unsigned WAIT_W     = 4,
  parameter int unsigned BOUND_GAP  = 2,
  parameter int unsigned BOUND_LOG2 = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          strobe,
  input  logic [AW-1:0] start_addr,
  input  logic [WAIT_W-1:0] cfg_wait,
  input  logic [1:0]    cfg_mode,
  output logic [AW-1:0] lead_addr,
  output bseq_mode_e    mode_q,
  output logic          lead_valid,
  output logic          lead_valid_nx
);
  localparam int unsigned GAP_BITS = (BOUND_GAP < 1) ? 1 : $clog2(BOUND_GAP + 1);
  localparam int unsigned CW       = (WAIT_W > GAP_BITS) ? WAIT_W : GAP_BITS;
  localparam logic [CW-1:0] ONE    = CW'(1);
  localparam logic [CW-1:0] GAP_LD = CW'(BOUND_GAP);
  localparam bit HAS_GAP           = (BOUND_GAP > 0);

  bseq_st_e      st, st_d;
  logic [CW-1:0] cnt, cnt_d;
  logic [AW-1:0] addr_d;
  bseq_mode_e    mode_d;
  logic [AW-1:0] step_addr, wmask;
  logic [CW-1:0] first_ld;
  logic          at_bound;

  bseq_addr_step #(.AW(AW)) u_step (
    .cur_addr (lead_addr),
    .mode     (mode_q),
    .nxt_addr (step_addr),
    .wrap_mask(wmask)
  );

  assign at_bound = &lead_addr[BOUND_LOG2-1:0];

  // The capture edge counts as one latency edge, so the counter holds L-1.
  always_comb begin
    if (cfg_wait < WAIT_W'(MIN_LATENCY)) first_ld = CW'(MIN_LATENCY - 1);
    else                                 first_ld = CW'(cfg_wait) - ONE;
  end

  always_comb begin
    st_d   = st;
    cnt_d  = cnt;
    addr_d = lead_addr;
    mode_d = mode_q;
    if (!en) begin
      st_d = S_IDLE;
    end else if (strobe) begin
      st_d   = S_WAIT;
      cnt_d  = first_ld;
      addr_d = start_addr;
      mode_d = bseq_mode_e'(cfg_mode);
    end else begin
      case (st)
        S_WAIT: begin
          if (cnt == ONE) st_d = S_BURST;
          else            cnt_d = cnt - ONE;
        end
        S_BURST: begin
          addr_d = step_addr;
          if (HAS_GAP && mode_q == M_LINEAR && at_bound) begin
            st_d  = S_GAP;
            cnt_d = GAP_LD;
          end
        end
        S_GAP: begin
          if (cnt == ONE) st_d = S_BURST;
          else            cnt_d = cnt - ONE;
        end
        default: st_d = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      cnt       <= '0;
      lead_addr <= '0;
      mode_q    <= M_LINEAR;
    end else begin
      st        <= st_d;
      cnt       <= cnt_d;
      lead_addr <= addr_d;
      mode_q    <= mode_d;
    end
  end

  assign lead_valid    = (st == S_BURST);
  assign lead_valid_nx = (st_d == S_BURST);

  // R3: a waiting or pausing sequencer never holds an exhausted counter
  p_cnt_live_r3: assert property (@(posedge clk) disable iff (rst)
    (st == S_WAIT || st == S_GAP) |-> (cnt != '0));

  // R5: a wrapping burst never changes the bits above its group
  p_wrap_group_r5: assert property (@(posedge clk) disable iff (rst)
    (st == S_BURST && en && !strobe && mode_q != M_LINEAR)
      |=> ((lead_addr | wmask) == $past(lead_addr | wmask)));

  // R10: the captured mode only moves on a capture edge
  p_mode_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !(en && strobe) |=> (mode_q == $past(mode_q)));

endmodule

// File: rtl/bseq_out_stage.sv
module bseq_out_stage #(
  parameter int unsigned AW = 22
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          strobe,
  input  logic          cfg_rdy_early,
  input  logic [AW-1:0] lead_addr,
  input  logic          lead_valid,
  input  logic          lead_valid_nx,
  output logic [AW-1:0] word_addr,
  output logic          word_valid,
  output logic          rdy
);
  logic early_q;

  always_ff @(posedge clk) begin
    if (rst || !en || strobe) begin
      word_addr  <= '0;
      word_valid <= 1'b0;
      rdy        <= 1'b0;
    end else begin
      word_addr  <= lead_addr;
      word_valid <= lead_valid;
      rdy        <= early_q ? lead_valid_nx : lead_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                early_q <= 1'b0;
    else if (en && strobe)  early_q <= cfg_rdy_early;
  end

  // R7: aligned ready mirrors valid
  p_rdy_aligned_r7: assert property (@(posedge clk) disable iff (rst)
    !early_q |-> (rdy == word_valid));

  // R8: early ready is always followed by a valid beat
  p_rdy_lead_r8: assert property (@(posedge clk) disable iff (rst)
    (early_q && rdy && en && !strobe) |=> word_valid);

  // R9: enable low empties the outputs
  p_kill_r9: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!word_valid && !rdy));

endmodule

// File: rtl/bseq_top.sv
module bseq_top
  import bseq_pkg::*;
#(
  parameter int unsigned AW         = 22,
  parameter int unsigned WAIT_W     = 4,
  parameter int unsigned BOUND_GAP  = 2,
  parameter int unsigned BOUND_LOG2 = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              strobe,
  input  logic [AW-1:0]     start_addr,
  input  logic [WAIT_W-1:0] cfg_wait,
  input  logic [1:0]        cfg_mode,
  input  logic              cfg_rdy_early,
  output logic [AW-1:0]     word_addr,
  output logic              word_valid,
  output logic              rdy
);
  logic [AW-1:0] lead_addr;
  bseq_mode_e    mode_q;
  logic          lead_valid, lead_valid_nx;

  bseq_lat_ctrl #(
    .AW(AW), .WAIT_W(WAIT_W), .BOUND_GAP(BOUND_GAP), .BOUND_LOG2(BOUND_LOG2)
  ) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .en           (en),
    .strobe       (strobe),
    .start_addr   (start_addr),
    .cfg_wait     (cfg_wait),
    .cfg_mode     (cfg_mode),
    .lead_addr    (lead_addr),
    .mode_q       (mode_q),
    .lead_valid   (lead_valid),
    .lead_valid_nx(lead_valid_nx)
  );

  bseq_out_stage #(.AW(AW)) u_out (
    .clk          (clk),
    .rst          (rst),
    .en           (en),
    .strobe       (strobe),
    .cfg_rdy_early(cfg_rdy_early),
    .lead_addr    (lead_addr),
    .lead_valid   (lead_valid),
    .lead_valid_nx(lead_valid_nx),
    .word_addr    (word_addr),
    .word_valid   (word_valid),
    .rdy          (rdy)
  );

  // R2: a capture edge always leaves the outputs idle
  p_capture_clears_r2: assert property (@(posedge clk) disable iff (rst)
    (en && strobe) |=> (!word_valid && !rdy));

  // R4: linear beats on consecutive cycles step by one
  p_lin_step_r4: assert property (@(posedge clk) disable iff (rst)
    (word_valid && en && !strobe && mode_q == M_LINEAR)
      |=> (!word_valid || word_addr == $past(word_addr) + AW'(1)));

  // R6: the beat that closes a 64-word block is followed by a pause
  if (BOUND_GAP > 0) begin : g_gap_chk
    p_bound_pause_r6: assert property (@(posedge clk) disable iff (rst)
      (word_valid && en && !strobe && mode_q == M_LINEAR
        && (&word_addr[BOUND_LOG2-1:0])) |=> !word_valid);
  end

endmodule

// File: tb/sim_bseq_top.sv
module sim_bseq_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 10;
  localparam int WAIT_W = 4;
  localparam int BOUND_GAP = 3;
  localparam int SPACE = 1 << AW;

  logic clk = 1'b0;
  logic rst, en, strobe, cfg_rdy_early;
  logic [AW-1:0] start_addr, word_addr;
  logic [WAIT_W-1:0] cfg_wait;
  logic [1:0] cfg_mode;
  logic word_valid, rdy;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  int q_v[$];
  int q_a[$];
  bit m_early = 0;
  int exp_v = 0, exp_r = 0, exp_a = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bseq_top #(.AW(AW), .WAIT_W(WAIT_W), .BOUND_GAP(BOUND_GAP), .BOUND_LOG2(6)) u0 (
    .clk(clk), .rst(rst), .en(en), .strobe(strobe), .start_addr(start_addr),
    .cfg_wait(cfg_wait), .cfg_mode(cfg_mode), .cfg_rdy_early(cfg_rdy_early),
    .word_addr(word_addr), .word_valid(word_valid), .rdy(rdy)
  );

  // Expected per-cycle schedule of one burst, from the requirements.
  task automatic build(int start, int w, int mode, bit early);
    int lat, n, base, off, a;
    q_v.delete(); q_a.delete();
    m_early = early;
    lat = (w < 2) ? 2 : w;
    for (int i = 1; i < lat; i++) begin q_v.push_back(0); q_a.push_back(0); end
    n = (mode == 0) ? SPACE : (4 << mode);
    base = start - (start % n);
    off = start % n;
    for (int k = 0; k < 300; k++) begin
      if (mode == 0) a = (start + k) % SPACE;
      else a = base + ((off + k) % n);
      q_v.push_back(1); q_a.push_back(a);
      if (mode == 0 && (a % 64) == 63)
        for (int g = 0; g < BOUND_GAP; g++) begin q_v.push_back(0); q_a.push_back(0); end
    end
  endtask

  task automatic model_edge();
    if (rst || !en) begin
      q_v.delete(); q_a.delete();
      exp_v = 0; exp_r = 0; exp_a = 0;
    end else if (strobe) begin
      build(int'(start_addr), int'(cfg_wait), int'(cfg_mode), cfg_rdy_early);
      exp_v = 0; exp_r = 0; exp_a = 0;
    end else begin
      if (q_v.size() > 0) begin
        exp_v = q_v.pop_front(); exp_a = q_a.pop_front();
      end else begin
        exp_v = 0; exp_a = 0;
      end
      if (m_early) exp_r = (q_v.size() > 0) ? q_v[0] : 0;
      else         exp_r = exp_v;
    end
  endtask

  task automatic compare(string tag, bit chk_addr);
    bit bad;
    checks++;
    bad = (int'(word_valid) != exp_v) || (int'(rdy) != exp_r) ||
          ((chk_addr || exp_v == 1) && int'(word_addr) != exp_a);
    if (bad) begin
      fails++;
      $display("FAIL %s: valid=%0d/%0d rdy=%0d/%0d addr=%0h/%0h (actual/expected)",
               tag, word_valid, exp_v, rdy, exp_r, word_addr, exp_a);
    end
  endtask

  task automatic tick(string tag, int n = 1, bit chk_addr = 0);
    for (int i = 0; i < n; i++) begin
      model_edge();
      @(posedge clk);
      @(negedge clk);
      if (!done) compare(tag, chk_addr);
    end
  endtask

  task automatic launch(int a, int w, int m, bit e);
    start_addr = AW'(a); cfg_wait = WAIT_W'(w); cfg_mode = 2'(m); cfg_rdy_early = e;
    strobe = 1'b1;
    tick("R2 capture");
    strobe = 1'b0;
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 20000 && !done) begin @(posedge clk); cyc++; end
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: run hung (actual timeout, expected completion)");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1; en = 0; strobe = 0; start_addr = '0; cfg_wait = '0; cfg_mode = '0; cfg_rdy_early = 0;
    tick("R1 reset", 3, 1);
    rst = 0; en = 1;
    tick("R1 idle", 2, 1);

    // Linear, aligned ready, crossing 64-word block with pause
    launch(60, 4, 0, 0);
    tick("R3 R4 R6 R7 linear", 20);

    // Wrap 8 starting at 39h, early ready
    launch('h39, 3, 1, 1);
    tick("R5 R8 wrap8", 20);

    // Wrap 16, aligned ready
    launch('h1A, 5, 2, 0);
    tick("R5 R7 wrap16", 25);

    // Wrap 32, early ready; inputs change under the running burst
    launch('h45, 6, 3, 1);
    cfg_mode = 0; cfg_wait = 9; cfg_rdy_early = 0; start_addr = 'h3C0;
    tick("R10 R5 wrap32", 45);

    // Latency clamp for 0 and 1
    launch('h100, 0, 0, 0);
    tick("R3 clamp0", 6);
    launch('h140, 1, 0, 1);
    tick("R3 R8 clamp1", 6);

    // Enable drop, strobe ignored while disabled
    launch('h200, 2, 0, 1);
    tick("R9 pre", 6);
    en = 0;
    tick("R9 drop", 1);
    strobe = 1; start_addr = 'h55;
    tick("R9 strobe ignored", 3);
    strobe = 0; en = 1;
    tick("R9 stays idle", 4);

    // Restart mid-burst
    launch('h10, 3, 0, 0);
    tick("R2 run", 5);
    launch('h27, 2, 1, 1);
    tick("R2 R5 restart", 15);

    // Linear through the top of the address space with pause
    launch(SPACE - 3, 2, 0, 1);
    tick("R4 R6 R8 top", 14);

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule